// File: doc/BRIEF.md
# Multi-Channel Fault Injector

This block sits inside a design under test, between internal logic and the pins that logic drives. It corrupts up to sixteen chosen signals on command, so that an injected fault can be followed from the inside of the design out to its I/O. Each channel takes a clean signal and returns a copy of it. When the channel is not faulting, the copy is the clean signal itself. When it is faulting, the copy is forced to 0, forced to 1, or inverted.

Software sets up the block through a small register port. It chooses a fault mode for each channel, an enable mask, a trigger source and a fault duration. It then arms the unit. A trigger then starts the fault on every enabled channel at once. The trigger is either a software strobe, or a match between a compare value and one of several observed buses. The fault lasts for the programmed number of cycles, or until software disarms the unit if the duration is zero. When a timed fault ends, the unit sets a sticky done flag.

Top module: `fault_inject_unit`

## Requirements
- R1: After reset the unit is idle (status state 0), done is 0, every configuration register reads 0 and `sig_o` equals `sig_i`.
- R2: `sig_o[i]` equals `sig_i[i]` whenever the unit is not active, the mask bit i is 0, or channel i's mode is 00.
- R3: While the unit is active with mask bit i set, channel i follows its 2-bit mode. Mode 01 drives 0. Mode 10 drives 1. Mode 11 drives the inverse of the present `sig_i[i]` in every cycle.
- R4: The register map is as follows. Address 0 is control on write and status on read, with status bits [1:0] the state (0 idle, 1 armed, 2 active) and bit 2 done. Address 1 is the channel mask. Address 2 is the compare value. Address 3 is the trigger setup, with bit 0 selecting compare triggering and bits [2:1] the observed bus. Address 4 is the duration. Address 5 holds the modes of channels 0-7 and address 6 those of channels 8-15, with two bits per channel and channel i at the lowest bits. Every configuration register reads back what was written.
- R5: Writing control bit 0 (arm) while idle moves the unit to armed. A control write with bit 2 (strobe) while armed with software triggering makes the unit active at the next clock edge. The unit never goes from idle to active directly.
- R6: While armed with compare triggering, the unit becomes active at the first clock edge at which the selected observed bus equals the compare value. The other buses are ignored.
- R7: A duration N greater than 0 keeps the unit active for exactly N cycles. The unit then returns to idle with done set to 1.
- R8: A duration of 0 keeps the unit active until it is disarmed.
- R9: Control bit 1 (disarm) returns the unit to idle from armed or active and leaves done unchanged.
- R10: Writes to configuration registers (addresses 1 to 6) made while the unit is armed or active are ignored.
- R11: Done stays set until software writes control bit 3 (clear). Done is set only when a timed fault ends.
- R12: Several channels fault in the same cycles, each in its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` (combinational) |
| obs_i | input | 64 | Four observed 16-bit buses for compare triggering |
| sig_i | input | 16 | Clean channel signals |
| sig_o | output | 16 | Possibly faulted channel signals |

## Verification
The checker asserts on every cycle that outputs pass through unchanged outside the active state, and that each enabled channel follows its stuck-at or flip mode while active. It also asserts that configuration stays unchanged across writes made while the unit is busy, that the unit cannot enter the active state without first being armed, and that done rises only when an active fault ends. The exact fault length for a given duration, the selection of the compare bus, persistence with a zero duration, and whether done stays set until cleared all depend on sequences of events, so the bench's directed and randomised scenarios show them.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } fi_state_e;

  typedef enum logic [1:0] {
    FM_NONE = 2'd0,
    FM_ST0  = 2'd1,
    FM_ST1  = 2'd2,
    FM_FLIP = 2'd3
  } fi_mode_e;

  localparam int A_CTRL  = 0;
  localparam int A_MASK  = 1;
  localparam int A_CMP   = 2;
  localparam int A_TRIG  = 3;
  localparam int A_DUR   = 4;
  localparam int A_MODE0 = 5;

  localparam int CB_ARM    = 0;
  localparam int CB_DISARM = 1;
  localparam int CB_STROBE = 2;
  localparam int CB_CLR    = 3;
endpackage

// File: rtl/fi_regs.sv
module fi_regs
  import fi_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int DW   = 16,
  parameter int NOBS = 4,
  parameter int AW   = 4,
  localparam int SELW = (NOBS > 1) ? $clog2(NOBS) : 1,
  localparam int NMR  = (2 * NCH + DW - 1) / DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  fi_state_e         state_i,
  input  logic              done_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    mask_o,
  output logic [2*NCH-1:0]  mode_o,
  output logic [DW-1:0]     cmp_o,
  output logic              src_cmp_o,
  output logic [SELW-1:0]   sel_o,
  output logic [DW-1:0]     dur_o
);
  logic [NCH-1:0]    mask_q;
  logic [NMR*DW-1:0] mode_q;
  logic [DW-1:0]     cmp_q, dur_q;
  logic              src_q;
  logic [SELW-1:0]   sel_q;
  logic              cfg_we;

  // configuration only moves while idle
  assign cfg_we = wr_en_i && (state_i == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cmp_q  <= '0;
      dur_q  <= '0;
      src_q  <= 1'b0;
      sel_q  <= '0;
    end else if (cfg_we) begin
      if (addr_i == AW'(A_MASK)) mask_q <= wdata_i[NCH-1:0];
      if (addr_i == AW'(A_CMP))  cmp_q  <= wdata_i;
      if (addr_i == AW'(A_DUR))  dur_q  <= wdata_i;
      if (addr_i == AW'(A_TRIG)) {sel_q, src_q} <= wdata_i[SELW:0];
    end
  end

  for (genvar g = 0; g < NMR; g++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[g*DW +: DW] <= '0;
      else if (cfg_we && addr_i == AW'(A_MODE0 + g))
        mode_q[g*DW +: DW] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CTRL))      rdata_o[2:0] = {done_i, state_i};
    else if (addr_i == AW'(A_MASK)) rdata_o[NCH-1:0] = mask_q;
    else if (addr_i == AW'(A_CMP))  rdata_o = cmp_q;
    else if (addr_i == AW'(A_DUR))  rdata_o = dur_q;
    else if (addr_i == AW'(A_TRIG)) rdata_o[SELW:0] = {sel_q, src_q};
    else begin
      for (int g = 0; g < NMR; g++)
        if (addr_i == AW'(A_MODE0 + g)) rdata_o = mode_q[g*DW +: DW];
    end
  end

  assign mask_o    = mask_q;
  assign mode_o    = mode_q[2*NCH-1:0];
  assign cmp_o     = cmp_q;
  assign dur_o     = dur_q;
  assign src_cmp_o = src_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NOBS = 4,
  localparam int SELW = (NOBS > 1) ? $clog2(NOBS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [3:0]        ctrl_i,
  input  logic              src_cmp_i,
  input  logic [SELW-1:0]   sel_i,
  input  logic [DW-1:0]     cmp_i,
  input  logic [DW-1:0]     dur_i,
  input  logic [NOBS*DW-1:0] obs_i,
  output fi_state_e         state_o,
  output logic              done_o
);
  fi_state_e     state_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] obs_sel;
  logic          hit;

  assign obs_sel = obs_i[sel_i*DW +: DW];
  assign hit = src_cmp_i ? (obs_sel == cmp_i) : (ctrl_we_i && ctrl_i[CB_STROBE]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      if (ctrl_we_i && ctrl_i[CB_CLR]) done_o <= 1'b0;
      if (ctrl_we_i && ctrl_i[CB_DISARM]) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE:
            if (ctrl_we_i && ctrl_i[CB_ARM]) state_q <= ST_ARMED;
          ST_ARMED:
            if (hit) begin
              state_q <= ST_ACTIVE;
              cnt_q   <= dur_i;
            end
          ST_ACTIVE:
            // zero count: hold until disarm
            if (cnt_q == DW'(1)) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end else if (cnt_q != '0) begin
              cnt_q <= cnt_q - DW'(1);
            end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/fi_chan.sv
module fi_chan
  import fi_pkg::*;
(
  input  logic       sig_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       active_i,
  output logic       sig_o
);
  always_comb begin
    sig_o = sig_i;
    if (active_i && en_i) begin
      unique case (fi_mode_e'(mode_i))
        FM_NONE: sig_o = sig_i;
        FM_ST0:  sig_o = 1'b0;
        FM_ST1:  sig_o = 1'b1;
        FM_FLIP: sig_o = ~sig_i;
        default: sig_o = sig_i;
      endcase
    end
  end
endmodule

// File: rtl/fault_inject_unit.sv
module fault_inject_unit
  import fi_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int DW   = 16,
  parameter int NOBS = 4,
  parameter int AW   = 4,
  localparam int SELW = (NOBS > 1) ? $clog2(NOBS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NOBS*DW-1:0] obs_i,
  input  logic [NCH-1:0]     sig_i,
  output logic [NCH-1:0]     sig_o
);
  fi_state_e          state;
  logic               done;
  logic [NCH-1:0]     mask;
  logic [2*NCH-1:0]   mode;
  logic [DW-1:0]      cmp, dur;
  logic               src_cmp;
  logic [SELW-1:0]    sel;
  logic               ctrl_we;
  logic               active;

  assign ctrl_we = wr_en_i && (addr_i == AW'(A_CTRL));
  assign active  = (state == ST_ACTIVE);

  fi_regs #(.NCH(NCH), .DW(DW), .NOBS(NOBS), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .state_i(state), .done_i(done), .rdata_o,
    .mask_o(mask), .mode_o(mode), .cmp_o(cmp),
    .src_cmp_o(src_cmp), .sel_o(sel), .dur_o(dur)
  );

  fi_ctrl #(.DW(DW), .NOBS(NOBS)) u_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i(ctrl_we), .ctrl_i(wdata_i[3:0]),
    .src_cmp_i(src_cmp), .sel_i(sel), .cmp_i(cmp), .dur_i(dur),
    .obs_i, .state_o(state), .done_o(done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fi_chan u_ch (
      .sig_i(sig_i[i]), .en_i(mask[i]), .mode_i(mode[2*i +: 2]),
      .active_i(active), .sig_o(sig_o[i])
    );
  end
endmodule

// File: rtl/fi_chk.sv
module fi_chk
  import fi_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 4,
  parameter int CW  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [1:0]       state_i,
  input logic             done_i,
  input logic [NCH-1:0]   sig_i,
  input logic [NCH-1:0]   sig_o,
  input logic [NCH-1:0]   mask_i,
  input logic [2*NCH-1:0] mode_i,
  input logic [CW-1:0]    cfg_i
);
  // R2
  pass_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_ACTIVE) |-> (sig_o == sig_i));

  // R11
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> ($past(state_i) == ST_ACTIVE));

  // R10
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != '0 && state_i != ST_IDLE) |=> $stable(cfg_i));

  // R5
  arm_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> (state_i != ST_ACTIVE));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // R3
    st0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_ACTIVE && mask_i[g] && mode_i[2*g +: 2] == FM_ST0) |-> !sig_o[g]);
    // R3
    st1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_ACTIVE && mask_i[g] && mode_i[2*g +: 2] == FM_ST1) |-> sig_o[g]);
    // R3
    flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == ST_ACTIVE && mask_i[g] && mode_i[2*g +: 2] == FM_FLIP) |-> (sig_o[g] == !sig_i[g]));
  end
endmodule

bind fault_inject_unit fi_chk #(
  .NCH(NCH), .AW(AW), .CW(NCH + 2*NCH + 2*DW + 1 + SELW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .state_i(state), .done_i(done), .sig_i(sig_i), .sig_o(sig_o),
  .mask_i(mask), .mode_i(mode), .cfg_i({mask, mode, cmp, dur, src_cmp, sel})
);

// File: tb/sim_fault_inject_unit.sv
module sim_fault_inject_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16, DW = 16, NOBS = 4, AW = 4;
  localparam logic [DW-1:0] C_ARM = 16'h1, C_DISARM = 16'h2, C_STROBE = 16'h4, C_CLR = 16'h8;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0, rdata_o, rd_v;
  logic [NOBS*DW-1:0] obs_i = '0;
  logic [NCH-1:0] sig_i = '0, sig_o;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_inject_unit u0 (.clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
                        .rdata_o, .obs_i, .sig_i, .sig_o);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    addr_i = AW'(a); wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    addr_i = AW'(a); #1; d = rdata_o;
  endtask

  function automatic logic [NCH-1:0] exp_out(logic [NCH-1:0] s, logic [NCH-1:0] m,
                                             logic [2*NCH-1:0] md, bit act);
    logic [NCH-1:0] o;
    for (int i = 0; i < NCH; i++) begin
      o[i] = s[i];
      if (act && m[i])
        case (md[2*i +: 2])
          2'b01: o[i] = 1'b0;
          2'b10: o[i] = 1'b1;
          2'b11: o[i] = ~s[i];
          default: o[i] = s[i];
        endcase
    end
    return o;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NCH-1:0] mask;
    logic [2*NCH-1:0] modes;
    int dur;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    sig_i = 16'hA5C3;
    rd(0, rd_v); check("R1 status", rd_v, 0);
    rd(1, rd_v); check("R1 mask", rd_v, 0);
    rd(6, rd_v); check("R1 modes", rd_v, 0);
    check("R1 passthrough", sig_o, 16'hA5C3);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 register readback
    wr(2, 16'h1357); rd(2, rd_v); check("R4 cmp", rd_v, 16'h1357);
    wr(3, 16'h0005); rd(3, rd_v); check("R4 trig", rd_v, 16'h0005);
    wr(4, 16'h0009); rd(4, rd_v); check("R4 dur", rd_v, 16'h0009);
    wr(5, 16'hC3A1); rd(5, rd_v); check("R4 mode lo", rd_v, 16'hC3A1);

    // R3 R7 R11 R12: directed then random timed faults
    for (int it = 0; it < 24; it++) begin
      mask = NCH'($urandom); modes = {16'($urandom), 16'($urandom)};
      dur = 1 + int'($urandom % 6);
      if (it == 0) begin mask = '1; modes = '1; dur = 1; end
      if (it == 1) begin mask = '1; modes = {NCH{2'b01}}; end
      if (it == 2) begin mask = '1; modes = {NCH{2'b10}}; end
      if (it == 3) begin mask = '0; end
      wr(1, mask); wr(5, modes[15:0]); wr(6, modes[31:16]);
      wr(3, 16'h0); wr(4, DW'(dur));
      wr(0, C_ARM);
      sig_i = NCH'($urandom); #1;
      check("R2 armed passthrough", sig_o, sig_i);
      rd(0, rd_v); check("R5 armed", rd_v, 16'h1);
      wr(0, C_STROBE);
      for (int c = 0; c < dur; c++) begin
        sig_i = NCH'($urandom); #1;
        check("R3 R12 faulted output", sig_o, exp_out(sig_i, mask, modes, 1'b1));
        @(negedge clk_i);
      end
      @(negedge clk_i);
      rd(0, rd_v); check("R7 idle with done", rd_v, 16'h4);
      sig_i = NCH'($urandom); #1;
      check("R2 after expiry", sig_o, sig_i);
      wr(0, C_CLR);
      rd(0, rd_v); check("R11 done cleared", rd_v, 16'h0);
    end

    // R6 compare trigger on bus 2
    wr(2, 16'hBEEF); wr(3, 16'h0005); wr(4, 16'h0); wr(1, 16'hFFFF);
    wr(5, 16'hFFFF); wr(6, 16'hFFFF);
    wr(0, C_ARM);
    obs_i[DW*0 +: DW] = 16'hBEEF; obs_i[DW*3 +: DW] = 16'hBEEF;
    repeat (3) @(negedge clk_i);
    rd(0, rd_v); check("R6 other bus ignored", rd_v, 16'h1);
    obs_i[DW*2 +: DW] = 16'hBEEF;
    @(negedge clk_i);
    obs_i = '0;
    rd(0, rd_v); check("R6 compare hit", rd_v, 16'h2);
    // R8 zero duration persists
    repeat (40) @(negedge clk_i);
    sig_i = 16'h0F0F; #1;
    check("R8 still faulting", sig_o, 16'hF0F0);
    // R10 write while active ignored
    wr(1, 16'h0001); rd(1, rd_v); check("R10 mask locked", rd_v, 16'hFFFF);
    // R9 disarm from active
    wr(0, C_DISARM);
    rd(0, rd_v); check("R9 disarm active", rd_v, 16'h0);

    // R9 disarm from armed keeps done
    wr(3, 16'h0); wr(4, 16'h1);
    wr(0, C_ARM); wr(0, C_STROBE); @(negedge clk_i);
    wr(0, C_ARM);
    wr(5, 16'h0000);
    rd(5, rd_v); check("R10 mode locked while armed", rd_v, 16'hFFFF);
    wr(0, C_DISARM);
    rd(0, rd_v); check("R9 R11 done kept after disarm", rd_v, 16'h4);
    repeat (3) @(negedge clk_i);
    rd(0, rd_v); check("R11 done sticky", rd_v, 16'h4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule